// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a multicycle processor datapath. A shared state graph steps each instruction through fetch, decode, execution, memory access and register write-back. Every step drives the datapath select lines and the write enables for the program counter, the instruction register, the register file and memory.

The block reads only the 6-bit opcode field of the instruction register. It handles five instruction classes: register-to-register ALU operations, word load, word store, branch-on-equal and jump. Branch and jump finish in 3 cycles, ALU operations and stores in 4, and loads in 5. After that the sequencer goes back to fetch.

The outputs are Moore outputs. They come only from the 4-bit state register, so the opcode affects only which state comes next.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state goes to fetch, so the fetch output pattern appears in the cycle after that edge.
- R2: In fetch, `pc_wr`, `mem_rd` and `ir_load` are 1, `alu_b_sel`=01, and all other outputs are 0. The next state is always decode.
- R3: In decode, `alu_b_sel`=11 and all other outputs are 0. The next state is chosen by opcode: 100011 (load) and 101011 (store) go to address compute, 000000 goes to ALU execute, 000100 goes to branch, and 000010 goes to jump.
- R4: A load goes fetch → decode → address compute (`alu_a_sel`=1, `alu_b_sel`=10) → memory read (`addr_sel`=1, `mem_rd`=1) → write-back (`rf_wr`=1, `wb_mem`=1, `rf_dst`=0) → fetch. That is 5 cycles.
- R5: A store goes fetch → decode → address compute → memory write (`addr_sel`=1, `mem_wr`=1) → fetch. That is 4 cycles.
- R6: An ALU operation goes fetch → decode → execute (`alu_a_sel`=1, `alu_b_sel`=00, `alu_mode`=10) → write-back (`rf_wr`=1, `rf_dst`=1, `wb_mem`=0) → fetch. That is 4 cycles.
- R7: A branch goes fetch → decode → compare (`alu_a_sel`=1, `alu_mode`=01, `pc_src`=01, `pc_wr_cond`=1) → fetch. That is 3 cycles.
- R8: A jump goes fetch → decode → jump (`pc_src`=10, `pc_wr`=1) → fetch. That is 3 cycles.
- R9: `mem_wr`, `rf_wr`, `ir_load` and `pc_wr` are 0 outside the states listed above. `pc_wr_cond` is 1 only in the branch compare state.
- R10: Any other opcode in decode returns to fetch on the next edge. No write enable is raised on the way.
- R11: The outputs depend only on the state. A change of `op` within a cycle leaves the outputs of that cycle unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op | input | 6 | Opcode field of the instruction register |
| pc_wr | output | 1 | Unconditional program counter write |
| pc_wr_cond | output | 1 | Program counter write if the ALU reports zero |
| addr_sel | output | 1 | Memory address select: 0 program counter, 1 ALU result register |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_load | output | 1 | Instruction register load |
| wb_mem | output | 1 | Register write data select: 1 memory data, 0 ALU result |
| pc_src | output | 2 | Next PC select: 00 ALU, 01 ALU result register, 10 jump target |
| alu_mode | output | 2 | ALU operation class: 00 add, 01 subtract, 10 function field |
| alu_a_sel | output | 1 | ALU A operand: 0 program counter, 1 register A |
| alu_b_sel | output | 2 | ALU B operand: 00 register B, 01 constant 4, 10 immediate, 11 shifted immediate |
| rf_wr | output | 1 | Register file write |
| rf_dst | output | 1 | Destination select: 1 rd field, 0 rt field |

## Verification
Each output pattern belongs to a state, and a state is entered at the rising edge after the state before it. The result of any opcode is therefore due one edge after decode. The whole length of each instruction class can be counted in edges from the fetch where it starts.

The bench drives `op` and samples every output on the falling edge. It compares the full output vector once per cycle against the state the requirement calls for in that cycle. It also checks that fetch comes back after exactly 3, 4 or 5 edges.

Reset is checked one edge after it is sampled. Opcode independence is checked by changing `op` between two falling-edge samples within a single cycle.

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm (
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] op,
  output logic       pc_wr,
  output logic       pc_wr_cond,
  output logic       addr_sel,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic       ir_load,
  output logic       wb_mem,
  output logic [1:0] pc_src,
  output logic [1:0] alu_mode,
  output logic       alu_a_sel,
  output logic [1:0] alu_b_sel,
  output logic       rf_wr,
  output logic       rf_dst
);

  localparam logic [5:0] OP_ALU = 6'b000000;
  localparam logic [5:0] OP_LD  = 6'b100011;
  localparam logic [5:0] OP_ST  = 6'b101011;
  localparam logic [5:0] OP_BR  = 6'b000100;
  localparam logic [5:0] OP_JMP = 6'b000010;

  typedef enum logic [3:0] {
    S_FETCH  = 4'd0,
    S_DEC    = 4'd1,
    S_ADDR   = 4'd2,
    S_LDMEM  = 4'd3,
    S_LDWB   = 4'd4,
    S_STMEM  = 4'd5,
    S_EXE    = 4'd6,
    S_ALUWB  = 4'd7,
    S_BRANCH = 4'd8,
    S_JUMP   = 4'd9
  } state_t;

  state_t state, state_nxt;

  always_ff @(posedge clk) begin
    if (rst) state <= S_FETCH;
    else     state <= state_nxt;
  end

  always_comb begin
    state_nxt = S_FETCH;
    case (state)
      S_FETCH: state_nxt = S_DEC;
      S_DEC: begin
        case (op)
          OP_LD, OP_ST: state_nxt = S_ADDR;
          OP_ALU:       state_nxt = S_EXE;
          OP_BR:        state_nxt = S_BRANCH;
          OP_JMP:       state_nxt = S_JUMP;
          default:      state_nxt = S_FETCH;
        endcase
      end
      S_ADDR:  state_nxt = (op == OP_ST) ? S_STMEM : S_LDMEM;
      S_LDMEM: state_nxt = S_LDWB;
      S_EXE:   state_nxt = S_ALUWB;
      default: state_nxt = S_FETCH;
    endcase
  end

  always_comb begin
    pc_wr      = 1'b0;
    pc_wr_cond = 1'b0;
    addr_sel   = 1'b0;
    mem_rd     = 1'b0;
    mem_wr     = 1'b0;
    ir_load    = 1'b0;
    wb_mem     = 1'b0;
    pc_src     = 2'b00;
    alu_mode   = 2'b00;
    alu_a_sel  = 1'b0;
    alu_b_sel  = 2'b00;
    rf_wr      = 1'b0;
    rf_dst     = 1'b0;
    case (state)
      S_FETCH: begin
        mem_rd    = 1'b1;
        ir_load   = 1'b1;
        pc_wr     = 1'b1;
        alu_b_sel = 2'b01;
      end
      S_DEC:   alu_b_sel = 2'b11;
      S_ADDR: begin
        alu_a_sel = 1'b1;
        alu_b_sel = 2'b10;
      end
      S_LDMEM: begin
        mem_rd   = 1'b1;
        addr_sel = 1'b1;
      end
      S_LDWB: begin
        rf_wr  = 1'b1;
        wb_mem = 1'b1;
      end
      S_STMEM: begin
        mem_wr   = 1'b1;
        addr_sel = 1'b1;
      end
      S_EXE: begin
        alu_a_sel = 1'b1;
        alu_mode  = 2'b10;
      end
      S_ALUWB: begin
        rf_wr  = 1'b1;
        rf_dst = 1'b1;
      end
      S_BRANCH: begin
        alu_a_sel  = 1'b1;
        alu_mode   = 2'b01;
        pc_src     = 2'b01;
        pc_wr_cond = 1'b1;
      end
      S_JUMP: begin
        pc_src = 2'b10;
        pc_wr  = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/mc_ctrl_fsm_chk.sv
module mc_ctrl_fsm_chk (
  input logic       clk,
  input logic       rst,
  input logic [5:0] op,
  input logic       pc_wr,
  input logic       pc_wr_cond,
  input logic       addr_sel,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       ir_load,
  input logic [1:0] pc_src,
  input logic [1:0] alu_b_sel,
  input logic       rf_wr
);

  logic in_dec;
  assign in_dec = (alu_b_sel == 2'b11) && !ir_load;

  // R1
  reset_to_fetch_chk: assert property (@(posedge clk) rst |=> ir_load);

  // R2
  fetch_next_dec_chk: assert property (@(posedge clk) disable iff (rst)
    ir_load |=> (alu_b_sel == 2'b11) && !ir_load);

  // R8
  jump_from_dec_chk: assert property (@(posedge clk) disable iff (rst)
    in_dec && op == 6'b000010 |=> pc_wr && pc_src == 2'b10);

  // R7
  branch_from_dec_chk: assert property (@(posedge clk) disable iff (rst)
    in_dec && op == 6'b000100 |=> pc_wr_cond && pc_src == 2'b01);

  // R9
  write_then_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_wr || rf_wr || pc_wr_cond) |=> ir_load);

  // R9
  cond_excl_chk: assert property (@(posedge clk) disable iff (rst)
    pc_wr_cond |-> !pc_wr && !mem_wr && !rf_wr && !ir_load);

  // R10
  bad_op_chk: assert property (@(posedge clk) disable iff (rst)
    in_dec && !(op inside {6'b000000, 6'b100011, 6'b101011, 6'b000100, 6'b000010})
      |=> ir_load);

  // R4
  ld_read_addr_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd && addr_sel |=> rf_wr);

endmodule

bind mc_ctrl_fsm mc_ctrl_fsm_chk u_chk (
  .clk(clk), .rst(rst), .op(op), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond),
  .addr_sel(addr_sel), .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_load(ir_load),
  .pc_src(pc_src), .alu_b_sel(alu_b_sel), .rf_wr(rf_wr)
);

// File: tb/tb_mc_ctrl_fsm.sv
module tb_mc_ctrl_fsm;
  localparam int CLK_PERIOD = 10;

  // vector: pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_load, wb_mem,
  //         pc_src[2], alu_mode[2], alu_a_sel, alu_b_sel[2], rf_wr, rf_dst
  localparam logic [15:0] V_FETCH = 16'b1_0_0_1_0_1_0_00_00_0_01_0_0;
  localparam logic [15:0] V_DEC   = 16'b0_0_0_0_0_0_0_00_00_0_11_0_0;
  localparam logic [15:0] V_ADDR  = 16'b0_0_0_0_0_0_0_00_00_1_10_0_0;
  localparam logic [15:0] V_LDMEM = 16'b0_0_1_1_0_0_0_00_00_0_00_0_0;
  localparam logic [15:0] V_LDWB  = 16'b0_0_0_0_0_0_1_00_00_0_00_1_0;
  localparam logic [15:0] V_STMEM = 16'b0_0_1_0_1_0_0_00_00_0_00_0_0;
  localparam logic [15:0] V_EXE   = 16'b0_0_0_0_0_0_0_00_10_1_00_0_0;
  localparam logic [15:0] V_ALUWB = 16'b0_0_0_0_0_0_0_00_00_0_00_1_1;
  localparam logic [15:0] V_BR    = 16'b0_1_0_0_0_0_0_01_01_1_00_0_0;
  localparam logic [15:0] V_JMP   = 16'b1_0_0_0_0_0_0_10_00_0_00_0_0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] op = 6'b0;
  logic pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_load, wb_mem;
  logic [1:0] pc_src, alu_mode, alu_b_sel;
  logic alu_a_sel, rf_wr, rf_dst;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_ctrl_fsm dut (
    .clk(clk), .rst(rst), .op(op), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond),
    .addr_sel(addr_sel), .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_load(ir_load),
    .wb_mem(wb_mem), .pc_src(pc_src), .alu_mode(alu_mode), .alu_a_sel(alu_a_sel),
    .alu_b_sel(alu_b_sel), .rf_wr(rf_wr), .rf_dst(rf_dst)
  );

  wire [15:0] outv = {pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_load, wb_mem,
                      pc_src, alu_mode, alu_a_sel, alu_b_sel, rf_wr, rf_dst};

  task automatic check(input string req, input logic [15:0] exp);
    n_chk++;
    if (outv !== exp) begin
      n_fail++;
      $display("FAIL %s: outputs %b expected %b", req, outv, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_seq(input string req, input logic [5:0] opc,
                         input logic [15:0] seq [6], input int n);
    op = opc;
    for (int i = 0; i < n; i++) begin
      check(req, seq[i]);
      if (i < n - 1) step();
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step();
    step();
    rst = 1'b0;
    check("R1", V_FETCH);
    check("R2", V_FETCH);
  endtask

  task automatic t_load();
    logic [15:0] s [6] = '{V_FETCH, V_DEC, V_ADDR, V_LDMEM, V_LDWB, V_FETCH};
    run_seq("R4", 6'b100011, s, 6);
  endtask

  task automatic t_store();
    logic [15:0] s [6] = '{V_FETCH, V_DEC, V_ADDR, V_STMEM, V_FETCH, 16'h0};
    run_seq("R5", 6'b101011, s, 5);
  endtask

  task automatic t_alu();
    logic [15:0] s [6] = '{V_FETCH, V_DEC, V_EXE, V_ALUWB, V_FETCH, 16'h0};
    run_seq("R6", 6'b000000, s, 5);
  endtask

  task automatic t_branch();
    logic [15:0] s [6] = '{V_FETCH, V_DEC, V_BR, V_FETCH, 16'h0, 16'h0};
    run_seq("R7", 6'b000100, s, 4);
  endtask

  task automatic t_jump();
    logic [15:0] s [6] = '{V_FETCH, V_DEC, V_JMP, V_FETCH, 16'h0, 16'h0};
    run_seq("R8", 6'b000010, s, 4);
  endtask

  task automatic t_bad_op(input logic [5:0] opc);
    logic [15:0] s [6] = '{V_FETCH, V_DEC, V_FETCH, 16'h0, 16'h0, 16'h0};
    run_seq("R10", opc, s, 3);
  endtask

  task automatic t_op_ignored();
    op = 6'b100011;
    check("R11", V_FETCH);
    #1 op = 6'b000010;
    #1 check("R11", V_FETCH);
    step();
    op = 6'b000000;
    #1 check("R11", V_DEC);
    step();
    check("R3", V_EXE);
    op = 6'b111111;
    #1 check("R11", V_EXE);
    step();
    check("R9", V_ALUWB);
    step();
    check("R9", V_FETCH);
  endtask

  task automatic t_reset_mid();
    op = 6'b100011;
    step();
    step();
    check("R3", V_ADDR);
    rst = 1'b1;
    step();
    rst = 1'b0;
    check("R1", V_FETCH);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_load();
    t_store();
    t_alu();
    t_branch();
    t_jump();
    t_bad_op(6'b111111);
    t_bad_op(6'b100000);
    t_op_ignored();
    t_jump();
    t_load();
    t_reset_mid();
    t_store();
    finish_run();
  end
endmodule